// File: doc/BRIEF.md
# Frame Rate Decimator and Repeater

This block schedules a frame buffer so that a full-rate video stream (60 frames per second) can be handled by a processing stage that runs at a quarter of that rate. It moves no pixel data. It only decides when the buffer is written, when it is read, and when its two halves change roles.

In down mode the block watches the incoming frame boundaries. It enables buffer writes for one frame, then counts three frames without storing them. During those three frames it asks the input pipe to drain. The stored stream therefore runs at 15 frames per second, and its pixel rate falls from about 25 MHz to about 6.2 MHz.

In up mode the block starts the reader and restarts it after each completed read. The same stored frame is played four times, so the display still receives pixels at the full clock rate. A swap of the buffer halves is requested only at the end of a four-read loop, and only if the writer has finished a newer frame by then. If no newer frame is ready, the old frame is played again and the output never stalls.

Top module: `frame_rate_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, every output is 0. Reset clears the frame counter, so the first frame after reset is stored.
- R2: In down mode, an `in_sof` pulse seen while the frame counter is 0 raises `wr_en` in the next cycle. `wr_en` stays high until the cycle after `in_eof`.
- R3: In down mode, an `in_sof` pulse seen while the counter is 1, 2 or 3 raises `pipe_flush` instead of `wr_en`, until the cycle after `in_eof`. `wr_en` and `pipe_flush` are never high together.
- R4: Each `in_sof` advances the 2-bit counter modulo 4. Exactly one frame in every four consecutive frames is stored: frames 0 and 4 after reset are written, frames 1 to 3 and 5 to 7 are flushed.
- R5: `frame_stored` is a one-cycle pulse in the cycle after an `in_eof` that ends a written frame. It stays low for flushed frames.
- R6: In up mode, `rd_start` pulses for one cycle in the first cycle after up mode is entered, and in the cycle after each `rd_frame_end`. `rd_pass` reports the read index 0, 1, 2, 3 within the loop.
- R7: When the `rd_frame_end` that ends read index 3 arrives, and a `wr_frame_done` pulse has been seen since the last swap (or arrives in the same cycle), `buf_swap` pulses together with `rd_start`, `rd_pass` returns to 0, and the pending flag clears.
- R8: When the fourth read ends with no new frame pending, `rd_start` still pulses, `rd_pass` returns to 0, and `buf_swap` stays low, so the old frame is read again.
- R9: Only the selected mode acts. In up mode, `in_sof` is ignored: `wr_en` and `pipe_flush` stay low and the counter does not move. In down mode, `rd_start` and `buf_swap` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_mode | input | 1 | 0 selects decimation (down), 1 selects repetition (up) |
| in_sof | input | 1 | Pulse marking the first pixel of an input frame |
| in_eof | input | 1 | Pulse marking the end of an input frame |
| wr_frame_done | input | 1 | Pulse from the writer: a new frame is complete in the spare half |
| rd_frame_end | input | 1 | Pulse from the reader: one full frame read is complete |
| wr_en | output | 1 | Buffer write enable for the current input frame |
| pipe_flush | output | 1 | Drain request for the input pipe during a skipped frame |
| frame_stored | output | 1 | One-cycle pulse after a written frame ends |
| rd_start | output | 1 | One-cycle pulse that starts a frame read |
| buf_swap | output | 1 | One-cycle pulse that exchanges the buffer halves |
| rd_pass | output | 2 | Index of the current read within the four-read loop |

## Verification
The properties assume that frame boundaries are well formed. Each `in_sof` and `in_eof` is a single-cycle pulse, the two never fall in the same cycle, and `rd_frame_end` comes only after a read has been started. The bench drives every pulse for exactly one clock, between falling edges. It always closes a frame with `in_eof` before the next `in_sof`. It changes `up_mode` only between frames, with no pulse pending.

// File: rtl/frc_pkg.sv
package frc_pkg;
  typedef enum logic {
    MODE_DOWN = 1'b0,
    MODE_UP   = 1'b1
  } frc_mode_t;

  function automatic logic is_last(input logic [7:0] idx, input int ratio);
    return idx == 8'(ratio - 1);
  endfunction
endpackage

// File: rtl/frc_decimator.sv
module frc_decimator #(
  parameter int RATIO = 4,
  parameter int CNT_W = $clog2(RATIO)
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic sof,
  input  logic eof,
  output logic wr_en,
  output logic flush,
  output logic stored
);
  import frc_pkg::*;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      wr_en  <= 1'b0;
      flush  <= 1'b0;
      stored <= 1'b0;
    end else begin
      stored <= 1'b0;
      if (!active) begin
        wr_en <= 1'b0;
        flush <= 1'b0;
      end else if (sof) begin
        wr_en <= (cnt == '0);
        flush <= (cnt != '0);
        cnt   <= is_last(8'(cnt), RATIO) ? '0 : cnt + 1'b1;
      end else if (eof) begin
        stored <= wr_en;
        wr_en  <= 1'b0;
        flush  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/frc_repeater.sv
module frc_repeater #(
  parameter int RATIO = 4,
  parameter int CNT_W = $clog2(RATIO)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             wr_done,
  input  logic             rd_end,
  output logic             rd_start,
  output logic             swap,
  output logic [CNT_W-1:0] pass
);
  import frc_pkg::*;

  logic pending;
  logic started;

  always_ff @(posedge clk) begin
    if (rst) begin
      pass     <= '0;
      pending  <= 1'b0;
      started  <= 1'b0;
      rd_start <= 1'b0;
      swap     <= 1'b0;
    end else begin
      rd_start <= 1'b0;
      swap     <= 1'b0;
      if (wr_done) pending <= 1'b1;
      if (!active) begin
        started <= 1'b0;
        pass    <= '0;
      end else if (!started) begin
        started  <= 1'b1;
        rd_start <= 1'b1;
      end else if (rd_end) begin
        rd_start <= 1'b1;
        if (is_last(8'(pass), RATIO)) begin
          pass <= '0;
          if (pending || wr_done) begin
            swap    <= 1'b1;
            pending <= 1'b0;
          end
        end else begin
          pass <= pass + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/frame_rate_ctrl.sv
module frame_rate_ctrl #(
  parameter int RATIO = 4,
  localparam int CNT_W = $clog2(RATIO)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_mode,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             wr_frame_done,
  input  logic             rd_frame_end,
  output logic             wr_en,
  output logic             pipe_flush,
  output logic             frame_stored,
  output logic             rd_start,
  output logic             buf_swap,
  output logic [CNT_W-1:0] rd_pass
);
  import frc_pkg::*;

  frc_mode_t mode;
  assign mode = frc_mode_t'(up_mode);

  frc_decimator #(.RATIO(RATIO), .CNT_W(CNT_W)) u_dec (
    .clk    (clk),
    .rst    (rst),
    .active (mode == MODE_DOWN),
    .sof    (in_sof),
    .eof    (in_eof),
    .wr_en  (wr_en),
    .flush  (pipe_flush),
    .stored (frame_stored)
  );

  frc_repeater #(.RATIO(RATIO), .CNT_W(CNT_W)) u_rep (
    .clk      (clk),
    .rst      (rst),
    .active   (mode == MODE_UP),
    .wr_done  (wr_frame_done),
    .rd_end   (rd_frame_end),
    .rd_start (rd_start),
    .swap     (buf_swap),
    .pass     (rd_pass)
  );
endmodule

// File: rtl/frc_checker.sv
module frc_checker #(
  parameter int RATIO = 4,
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             up_mode,
  input logic             in_sof,
  input logic             wr_en,
  input logic             pipe_flush,
  input logic             frame_stored,
  input logic             rd_start,
  input logic             buf_swap,
  input logic [CNT_W-1:0] rd_pass
);
  // R3: writing and draining are exclusive
  assert_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && pipe_flush));

  // R2: the write window opens only on a frame start
  assert_wr_rise_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_en) |-> $past(in_sof));

  // R5: a stored pulse follows a closing write window
  assert_stored_R5: assert property (@(posedge clk) disable iff (rst)
    frame_stored |-> ($past(wr_en) && !wr_en));

  // R7: a swap only accompanies a restart at the loop end
  assert_swap_R7: assert property (@(posedge clk) disable iff (rst)
    buf_swap |-> (rd_start && rd_pass == '0 && $past(rd_pass) == CNT_W'(RATIO - 1)));

  // R9: each side stays quiet while the other mode is selected
  assert_down_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !up_mode |=> !(rd_start || buf_swap));
  assert_up_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    up_mode |=> !(wr_en || pipe_flush));
endmodule

bind frame_rate_ctrl frc_checker #(.RATIO(RATIO), .CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_frame_rate_ctrl.sv
module test_frame_rate_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up_mode = 1'b0;
  logic in_sof = 1'b0;
  logic in_eof = 1'b0;
  logic wr_frame_done = 1'b0;
  logic rd_frame_end = 1'b0;
  logic wr_en, pipe_flush, frame_stored, rd_start, buf_swap;
  logic [1:0] rd_pass;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  frame_rate_ctrl i_frame_rate_ctrl (
    .clk(clk), .rst(rst), .up_mode(up_mode), .in_sof(in_sof), .in_eof(in_eof),
    .wr_frame_done(wr_frame_done), .rd_frame_end(rd_frame_end),
    .wr_en(wr_en), .pipe_flush(pipe_flush), .frame_stored(frame_stored),
    .rd_start(rd_start), .buf_swap(buf_swap), .rd_pass(rd_pass)
  );

  // Down-mode table, one entry per frame after reset: expected {wr_en, pipe_flush, frame_stored}
  localparam logic [2:0] DOWN_VEC [8] = '{3'b101, 3'b010, 3'b010, 3'b010,
                                          3'b101, 3'b010, 3'b010, 3'b010};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk) sig = 1'b1;
    @(negedge clk) sig = 1'b0;
  endtask

  // Runs one input frame. Checks the write/flush window and the stored pulse.
  task automatic frame(input string req, input bit exp_wr, input bit exp_fl, input bit exp_st);
    pulse(in_sof);
    repeat (2) @(negedge clk);
    chk({req, " wr_en"}, int'(wr_en), int'(exp_wr));
    chk({req, " pipe_flush"}, int'(pipe_flush), int'(exp_fl));
    pulse(in_eof);
    chk({req, " frame_stored"}, int'(frame_stored), int'(exp_st));
    chk({req, " window closed"}, int'(wr_en | pipe_flush), 0);
  endtask

  task automatic rd_end_chk(input string req, input bit swp, input int pass_exp);
    pulse(rd_frame_end);
    chk({req, " rd_start"}, int'(rd_start), 1);
    chk({req, " buf_swap"}, int'(buf_swap), int'(swp));
    chk({req, " rd_pass"}, int'(rd_pass), pass_exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset outputs", int'({wr_en, pipe_flush, frame_stored, rd_start, buf_swap, rd_pass}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", int'({wr_en, pipe_flush, frame_stored, rd_start, buf_swap, rd_pass}), 0);

    // R2 R3 R4 R5: walk the down-mode table
    for (int i = 0; i < 8; i++) begin
      frame($sformatf("R4 frame%0d", i), DOWN_VEC[i][2], DOWN_VEC[i][1], DOWN_VEC[i][0]);
    end

    // R1: a reset in mid-count makes the next frame a written one
    frame("R3 skip before reset", 1'b1, 1'b0, 1'b1);
    frame("R3 skip before reset", 1'b0, 1'b1, 1'b0);
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    frame("R1 first frame after reset", 1'b1, 1'b0, 1'b1);
    frame("R3 next skipped", 1'b0, 1'b1, 1'b0);
    frame("R3 next skipped", 1'b0, 1'b1, 1'b0);
    frame("R3 next skipped", 1'b0, 1'b1, 1'b0);

    // R9: the read side stays quiet in down mode
    pulse(rd_frame_end);
    chk("R9 down rd_start", int'(rd_start), 0);
    chk("R9 down buf_swap", int'(buf_swap), 0);

    // R6: entering up mode starts a read
    @(negedge clk) up_mode = 1'b1;
    @(negedge clk);
    chk("R6 entry rd_start", int'(rd_start), 1);
    chk("R6 entry rd_pass", int'(rd_pass), 0);
    @(negedge clk);
    chk("R6 single pulse", int'(rd_start), 0);

    // R9: frame starts are ignored in up mode
    frame("R9 up ignores sof", 1'b0, 1'b0, 1'b0);
    frame("R9 up ignores sof", 1'b0, 1'b0, 1'b0);

    // R6 R8: a loop with no new frame replays the old one
    rd_end_chk("R6 pass1", 1'b0, 1);
    rd_end_chk("R6 pass2", 1'b0, 2);
    rd_end_chk("R6 pass3", 1'b0, 3);
    rd_end_chk("R8 no frame, no swap", 1'b0, 0);

    // R7: a frame finishes mid-loop, so the swap happens at the loop end
    pulse(wr_frame_done);
    chk("R7 wr_done alone no start", int'(rd_start), 0);
    rd_end_chk("R7 pass1", 1'b0, 1);
    rd_end_chk("R7 pass2", 1'b0, 2);
    rd_end_chk("R7 pass3", 1'b0, 3);
    rd_end_chk("R7 swap at loop end", 1'b1, 0);

    // R8: the pending flag cleared, so the next loop does not swap
    rd_end_chk("R8 pass1", 1'b0, 1);
    rd_end_chk("R8 pass2", 1'b0, 2);
    rd_end_chk("R8 pass3", 1'b0, 3);
    rd_end_chk("R8 cleared pending", 1'b0, 0);

    // R7: the writer finishes in the same cycle as the fourth read
    rd_end_chk("R7 pass1b", 1'b0, 1);
    rd_end_chk("R7 pass2b", 1'b0, 2);
    rd_end_chk("R7 pass3b", 1'b0, 3);
    @(negedge clk) begin rd_frame_end = 1'b1; wr_frame_done = 1'b1; end
    @(negedge clk) begin rd_frame_end = 1'b0; wr_frame_done = 1'b0; end
    chk("R7 coincident swap", int'(buf_swap), 1);
    chk("R7 coincident start", int'(rd_start), 1);

    // R9: the counter held during up mode, so the next down frame is written
    @(negedge clk) up_mode = 1'b0;
    @(negedge clk);
    frame("R9 counter held", 1'b1, 1'b0, 1'b1);
    frame("R4 after return", 1'b0, 1'b1, 1'b0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule